// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block lets a client reach the registers of the PHYs embedded in a switch without knowing the switch's indirect access scheme. The client presents one request: a PHY number, a page, a register number, a read/write flag and, for writes, 16 bits of data. The block checks the request. It then runs a short series of switch-register transactions through a simple command port, where each command is a one-cycle `cmd_req` pulse answered later by a one-cycle `cmd_done`. It ends with a one-cycle `done` that carries a fault code and, for a successful read, the PHY register value.

Every PHY access starts by writing the access-control register (0x8028) with the direction: 1 for read, 0 for write. Next comes a write to a window address. That address is 0x8000 with three fields added: a one-hot bit selecting the PHY (bit 9 + PHY number), the page in bits 7:5 and the register number in bits 4:0. A PHY write puts its data in this second transaction. A PHY read writes 0 there and then reads the access-data register (0x8029), whose value is returned.

The controller has ten named states. `ST_IDLE` goes to `ST_CTRL_ISSUE` for an accepted in-range request, or to `ST_DONE_RANGE` for one that is out of range. The issue states step to their wait states: `ST_CTRL_ISSUE`→`ST_CTRL_WAIT`, `ST_WIN_ISSUE`→`ST_WIN_WAIT` and `ST_DATA_ISSUE`→`ST_DATA_WAIT`. A clean completion moves `ST_CTRL_WAIT`→`ST_WIN_ISSUE`. From `ST_WIN_WAIT` a clean completion goes to `ST_DONE_OK` for a write or to `ST_DATA_ISSUE` for a read, and from `ST_DATA_WAIT` it goes to `ST_DONE_OK`. Any wait state that sees an errored completion goes to `ST_DONE_BUS`. `ST_DONE_OK`, `ST_DONE_RANGE` and `ST_DONE_BUS` each return to `ST_IDLE` after one cycle.

Top module: `phy_window_seq`

## Requirements
- R1: A request with PHY number above 4, page above 7 or register number above 31 issues no command; `done` rises in the cycle after acceptance with `err_kind` = 1 (range fault).
- R2: The first command of an accepted request is a write (`cmd_write`=1) to address 0x8028 carrying data 1 for a PHY read and 0 for a PHY write.
- R3: The second command is a write to 0x8000 | (1 << (PHY+9)) | ((page << 5) & 0x00E0) | (register & 0x1F).
- R4: The second command carries the request's write data for a PHY write and 0 for a PHY read.
- R5: A PHY read issues a third command, a read (`cmd_write`=0) of address 0x8029. On its clean completion `done` rises with `err_kind` = 0 and `rd_data` equal to the returned `cmd_rdata`.
- R6: A PHY write finishes after exactly two commands with `err_kind` = 0. `rd_data` is cleared to 0 on every acceptance, so it reads 0 after a write.
- R7: A completion with `cmd_err` = 1 stops the sequence. No further command is issued, and `done` rises the next cycle with `err_kind` = 2 (bus fault).
- R8: `busy` is high from the cycle after acceptance through the single `done` cycle. A `req_valid` seen while `busy` is high is ignored.
- R9: `cmd_req` lasts one cycle, and no new `cmd_req` is issued until the previous command's `cmd_done` has arrived.
- R10: Reset leaves the outputs `busy`, `done`, `cmd_req`, `err_kind` and `rd_data` all low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while not busy |
| req_write | input | 1 | 1 = PHY write, 0 = PHY read |
| req_phy | input | 5 | PHY number |
| req_page | input | 4 | Page number |
| req_reg | input | 6 | PHY register number |
| req_wdata | input | 16 | Data for a PHY write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_kind | output | 2 | Fault code during done: 0 none, 1 range, 2 bus |
| rd_data | output | 16 | PHY read result |
| cmd_req | output | 1 | One-cycle command pulse to the register master |
| cmd_write | output | 1 | Command direction, 1 = write |
| cmd_addr | output | 16 | Switch register address |
| cmd_wdata | output | 16 | Command write data |
| cmd_done | input | 1 | Command completion pulse |
| cmd_err | input | 1 | Command failed, valid with cmd_done |
| cmd_rdata | input | 16 | Command read data, valid with cmd_done |

## Verification
A controller that skips or repeats a state shows up on the command port at once. The next `cmd_req` appears with the wrong address, the wrong direction or the wrong ordinal, or appears while a command is still outstanding, so a per-request command log catches it on that pulse. A stuck or stale phase shows up at the final `done`. The fault code, the read value or the number of commands issued no longer matches what the request and the injected completions imply. One cycle later `busy` either stays high or drops, which exposes a wrong return to `ST_IDLE`.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_CTRL_ISSUE = 4'd1,
        ST_CTRL_WAIT  = 4'd2,
        ST_WIN_ISSUE  = 4'd3,
        ST_WIN_WAIT   = 4'd4,
        ST_DATA_ISSUE = 4'd5,
        ST_DATA_WAIT  = 4'd6,
        ST_DONE_OK    = 4'd7,
        ST_DONE_RANGE = 4'd8,
        ST_DONE_BUS   = 4'd9
    } seq_state_e;

    typedef enum logic [1:0] {
        FAULT_NONE  = 2'd0,
        FAULT_RANGE = 2'd1,
        FAULT_BUS   = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        PH_CTRL = 2'd0,
        PH_WIN  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

endpackage

// File: rtl/phy_req_check.sv
module phy_req_check #(
    parameter int PHY_W    = 5,
    parameter int PAGE_W   = 4,
    parameter int REG_W    = 6,
    parameter int MAX_PHY  = 4,
    parameter int MAX_PAGE = 7,
    parameter int MAX_REG  = 31
) (
    input  logic [PHY_W-1:0]  phy,
    input  logic [PAGE_W-1:0] page,
    input  logic [REG_W-1:0]  regn,
    output logic              in_range
);
    localparam logic [PHY_W-1:0]  PHY_LIM  = PHY_W'(MAX_PHY);
    localparam logic [PAGE_W-1:0] PAGE_LIM = PAGE_W'(MAX_PAGE);
    localparam logic [REG_W-1:0]  REG_LIM  = REG_W'(MAX_REG);

    logic phy_ok, page_ok, reg_ok;

    always_comb begin
        phy_ok   = (phy  <= PHY_LIM);
        page_ok  = (page <= PAGE_LIM);
        reg_ok   = (regn <= REG_LIM);
        in_range = phy_ok && page_ok && reg_ok;
    end
endmodule

// File: rtl/phy_win_addr.sv
module phy_win_addr #(
    parameter int              ADDR_W     = 16,
    parameter int              PHY_W      = 5,
    parameter int              PAGE_W     = 4,
    parameter int              REG_W      = 6,
    parameter logic [15:0]     WIN_BASE   = 16'h8000,
    parameter int              PHY_SHIFT  = 9,
    parameter int              PAGE_SHIFT = 5,
    parameter int              PAGE_BITS  = 3,
    parameter int              REG_BITS   = 5
) (
    input  logic [PHY_W-1:0]  phy,
    input  logic [PAGE_W-1:0] page,
    input  logic [REG_W-1:0]  regn,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BASE      = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(((1 << PAGE_BITS) - 1) << PAGE_SHIFT);
    localparam logic [ADDR_W-1:0] REG_MASK  = ADDR_W'((1 << REG_BITS) - 1);

    logic [ADDR_W-1:0] phy_sel;
    logic [ADDR_W-1:0] page_fld;
    logic [ADDR_W-1:0] reg_fld;

    // One-hot PHY select: bit (PHY_SHIFT + n) set when phy == n
    for (genvar b = 0; b < ADDR_W; b++) begin : g_sel
        if (b >= PHY_SHIFT) begin : g_live
            assign phy_sel[b] = (phy == PHY_W'(b - PHY_SHIFT));
        end else begin : g_zero
            assign phy_sel[b] = 1'b0;
        end
    end

    always_comb begin
        page_fld = (ADDR_W'(page) << PAGE_SHIFT) & PAGE_MASK;
        reg_fld  = ADDR_W'(regn) & REG_MASK;
        addr     = BASE | phy_sel | page_fld | reg_fld;
    end
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
    import phy_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   in_range,
    input  logic   op_write,
    input  logic   cmd_done,
    input  logic   cmd_err,
    output logic   accept,
    output logic   capture,
    output logic   busy,
    output logic   done,
    output fault_e fault,
    output logic   cmd_req,
    output logic   cmd_write,
    output phase_e phase
);
    seq_state_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = in_range ? ST_CTRL_ISSUE : ST_DONE_RANGE;
            ST_CTRL_ISSUE: state_nx = ST_CTRL_WAIT;
            ST_CTRL_WAIT:  if (cmd_done) state_nx = cmd_err ? ST_DONE_BUS : ST_WIN_ISSUE;
            ST_WIN_ISSUE:  state_nx = ST_WIN_WAIT;
            ST_WIN_WAIT:   if (cmd_done) begin
                               if (cmd_err)       state_nx = ST_DONE_BUS;
                               else if (op_write) state_nx = ST_DONE_OK;
                               else               state_nx = ST_DATA_ISSUE;
                           end
            ST_DATA_ISSUE: state_nx = ST_DATA_WAIT;
            ST_DATA_WAIT:  if (cmd_done) state_nx = cmd_err ? ST_DONE_BUS : ST_DONE_OK;
            ST_DONE_OK,
            ST_DONE_RANGE,
            ST_DONE_BUS:   state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        accept    = 1'b0;
        capture   = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        fault     = FAULT_NONE;
        cmd_req   = 1'b0;
        cmd_write = 1'b1;
        phase     = PH_CTRL;
        unique case (state)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = req_valid;
            end
            ST_CTRL_ISSUE: cmd_req = 1'b1;
            ST_CTRL_WAIT:  phase = PH_CTRL;
            ST_WIN_ISSUE: begin
                cmd_req = 1'b1;
                phase   = PH_WIN;
            end
            ST_WIN_WAIT:   phase = PH_WIN;
            ST_DATA_ISSUE: begin
                cmd_req   = 1'b1;
                cmd_write = 1'b0;
                phase     = PH_DATA;
            end
            ST_DATA_WAIT: begin
                cmd_write = 1'b0;
                phase     = PH_DATA;
                capture   = cmd_done && !cmd_err;
            end
            ST_DONE_OK:    done = 1'b1;
            ST_DONE_RANGE: begin
                done  = 1'b1;
                fault = FAULT_RANGE;
            end
            ST_DONE_BUS: begin
                done  = 1'b1;
                fault = FAULT_BUS;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/phy_window_seq.sv
module phy_window_seq
    import phy_seq_pkg::*;
#(
    parameter int          PHY_W      = 5,
    parameter int          PAGE_W     = 4,
    parameter int          REG_W      = 6,
    parameter int          DATA_W     = 16,
    parameter int          ADDR_W     = 16,
    parameter int          MAX_PHY    = 4,
    parameter int          MAX_PAGE   = 7,
    parameter int          MAX_REG    = 31,
    parameter logic [15:0] CTRL_ADDR  = 16'h8028,
    parameter logic [15:0] DATA_ADDR  = 16'h8029,
    parameter logic [15:0] WIN_BASE   = 16'h8000,
    parameter int          PHY_SHIFT  = 9,
    parameter int          PAGE_SHIFT = 5,
    parameter int          PAGE_BITS  = 3,
    parameter int          REG_BITS   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_kind,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_req,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_done,
    input  logic              cmd_err,
    input  logic [DATA_W-1:0] cmd_rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] DATA_A   = ADDR_W'(DATA_ADDR);
    localparam logic [DATA_W-1:0] DIR_READ = DATA_W'(1);

    logic              in_range;
    logic              accept, capture;
    fault_e            fault;
    phase_e            phase;
    logic              op_write;
    logic [PHY_W-1:0]  phy_q;
    logic [PAGE_W-1:0] page_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] win_addr;

    phy_req_check #(
        .PHY_W(PHY_W), .PAGE_W(PAGE_W), .REG_W(REG_W),
        .MAX_PHY(MAX_PHY), .MAX_PAGE(MAX_PAGE), .MAX_REG(MAX_REG)
    ) u_check (
        .phy(req_phy), .page(req_page), .regn(req_reg), .in_range(in_range)
    );

    phy_win_addr #(
        .ADDR_W(ADDR_W), .PHY_W(PHY_W), .PAGE_W(PAGE_W), .REG_W(REG_W),
        .WIN_BASE(WIN_BASE), .PHY_SHIFT(PHY_SHIFT), .PAGE_SHIFT(PAGE_SHIFT),
        .PAGE_BITS(PAGE_BITS), .REG_BITS(REG_BITS)
    ) u_win (
        .phy(phy_q), .page(page_q), .regn(reg_q), .addr(win_addr)
    );

    phy_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .in_range(in_range),
        .op_write(op_write), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .accept(accept), .capture(capture), .busy(busy), .done(done),
        .fault(fault), .cmd_req(cmd_req), .cmd_write(cmd_write), .phase(phase)
    );

    // Request capture and read-result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            phy_q    <= '0;
            page_q   <= '0;
            reg_q    <= '0;
            wdata_q  <= '0;
            rd_data  <= '0;
        end else if (accept) begin
            op_write <= req_write;
            phy_q    <= req_phy;
            page_q   <= req_page;
            reg_q    <= req_reg;
            wdata_q  <= req_wdata;
            rd_data  <= '0;
        end else if (capture) begin
            rd_data  <= cmd_rdata;
        end
    end

    // Command address and data by phase
    always_comb begin
        unique case (phase)
            PH_CTRL: begin
                cmd_addr  = CTRL_A;
                cmd_wdata = op_write ? '0 : DIR_READ;
            end
            PH_WIN: begin
                cmd_addr  = win_addr;
                cmd_wdata = op_write ? wdata_q : '0;
            end
            default: begin
                cmd_addr  = DATA_A;
                cmd_wdata = '0;
            end
        endcase
    end

    assign err_kind = fault;
endmodule

// File: rtl/phy_window_seq_chk.sv
module phy_window_seq_chk #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] CTRL_ADDR = 16'h8028,
    parameter logic [15:0] DATA_ADDR = 16'h8029
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [DATA_W-1:0] req_wdata,
    input logic              busy,
    input logic              done,
    input logic [1:0]        err_kind,
    input logic              cmd_req,
    input logic              cmd_write,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic              cmd_done,
    input logic              cmd_err
);
    logic [1:0]        n_cmd;
    logic              wr_l;
    logic [DATA_W-1:0] wd_l;
    logic              pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_cmd   <= '0;
            wr_l    <= 1'b0;
            wd_l    <= '0;
            pending <= 1'b0;
        end else begin
            if (req_valid && !busy) begin
                n_cmd <= '0;
                wr_l  <= req_write;
                wd_l  <= req_wdata;
            end else if (cmd_req && n_cmd != 2'd3) begin
                n_cmd <= n_cmd + 2'd1;
            end
            if (cmd_req)       pending <= 1'b1;
            else if (cmd_done) pending <= 1'b0;
        end
    end

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_kind == 2'd1) |-> n_cmd == 2'd0); // R1
    AST_CTRL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && n_cmd == 2'd0) |-> (cmd_write && cmd_addr == ADDR_W'(CTRL_ADDR)
            && cmd_wdata == (wr_l ? '0 : DATA_W'(1)))); // R2
    AST_WIN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && n_cmd == 2'd1) |-> (cmd_write && cmd_wdata == (wr_l ? wd_l : '0))); // R4
    AST_DATA_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && n_cmd == 2'd2) |-> (!wr_l && !cmd_write && cmd_addr == ADDR_W'(DATA_ADDR))); // R5
    AST_WRITE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_kind == 2'd0 && wr_l) |-> n_cmd == 2'd2); // R6
    AST_ABORT_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_kind == 2'd2) |-> $past(cmd_done && cmd_err)); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> !cmd_req); // R9
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !cmd_req); // R9
endmodule

bind phy_window_seq phy_window_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .busy(busy), .done(done), .err_kind(err_kind),
    .cmd_req(cmd_req), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_err(cmd_err)
);

// File: tb/test_phy_window_seq.sv
module test_phy_window_seq;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [3:0]  page;
        logic [5:0]  regn;
        logic [15:0] wd;
        logic [15:0] rd;
        logic [1:0]  err_at;
        logic [1:0]  lat;
        logic        hold;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd0, 4'd0, 6'd0,  16'h0000, 16'h1234, 2'd0, 2'd1, 1'b0},
        '{1'b1, 5'd4, 4'd7, 6'd31, 16'hBEEF, 16'h5555, 2'd0, 2'd2, 1'b0},
        '{1'b0, 5'd2, 4'd3, 6'd17, 16'h0000, 16'hA5C3, 2'd0, 2'd3, 1'b0},
        '{1'b1, 5'd1, 4'd5, 6'd9,  16'h0F0F, 16'h9999, 2'd0, 2'd1, 1'b1},
        '{1'b0, 5'd5, 4'd0, 6'd0,  16'h0000, 16'h1111, 2'd0, 2'd1, 1'b0},
        '{1'b1, 5'd0, 4'd8, 6'd3,  16'h2222, 16'h1111, 2'd0, 2'd1, 1'b0},
        '{1'b0, 5'd3, 4'd1, 6'd32, 16'h0000, 16'h1111, 2'd0, 2'd1, 1'b0},
        '{1'b0, 5'd1, 4'd2, 6'd4,  16'h0000, 16'hCAFE, 2'd1, 2'd1, 1'b0},
        '{1'b1, 5'd2, 4'd6, 6'd20, 16'h3C3C, 16'hCAFE, 2'd2, 2'd2, 1'b0},
        '{1'b0, 5'd4, 4'd4, 6'd1,  16'h0000, 16'hCAFE, 2'd3, 2'd1, 1'b0},
        '{1'b0, 5'd3, 4'd0, 6'd2,  16'h0000, 16'h7E81, 2'd0, 2'd1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [3:0]  req_page = '0;
    logic [5:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, cmd_req, cmd_write;
    logic [1:0]  err_kind;
    logic [15:0] rd_data, cmd_addr, cmd_wdata;
    logic        cmd_done = 1'b0, cmd_err = 1'b0;
    logic [15:0] cmd_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    phy_window_seq i_phy_window_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_page(req_page), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err_kind(err_kind), .rd_data(rd_data),
        .cmd_req(cmd_req), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] win_of(input vec_t v);
        return 16'h8000 | (16'h1 << (v.phy + 5'd9)) | ((16'(v.page) << 5) & 16'h00E0) | (16'(v.regn) & 16'h001F);
    endfunction

    task automatic run_vec(input vec_t v);
        logic [15:0] lg_addr [4];
        logic        lg_wr   [4];
        logic [15:0] lg_wd   [4];
        int   ntx = 0, wcnt = 0, n_full, n_exp;
        bit   got = 0, valid, overlap = 0;
        logic [1:0]  k_exp, k_act = '0;
        logic [15:0] rd_exp, rd_act = '0;

        valid  = (v.phy <= 5'd4) && (v.page <= 4'd7) && (v.regn <= 6'd31);
        n_full = v.wr ? 2 : 3;
        if (!valid) begin
            n_exp = 0; k_exp = 2'd1;
        end else if (v.err_at != 0 && int'(v.err_at) <= n_full) begin
            n_exp = int'(v.err_at); k_exp = 2'd2;
        end else begin
            n_exp = n_full; k_exp = 2'd0;
        end
        rd_exp = (k_exp == 2'd0 && !v.wr) ? v.rd : 16'h0;

        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_phy = v.phy;
        req_page = v.page; req_reg = v.regn; req_wdata = v.wd;
        for (int c = 0; c < 60 && !got; c++) begin
            @(negedge clk);
            if (c == 0) begin
                chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
                if (!v.hold) req_valid = 1'b0;
                else begin
                    req_write = ~v.wr; req_phy = 5'd0; req_reg = v.regn ^ 6'd1;
                end
            end
            cmd_done = 1'b0; cmd_err = 1'b0;
            if (done) begin
                got = 1; k_act = err_kind; rd_act = rd_data;
            end else if (cmd_req) begin
                if (wcnt != 0) overlap = 1;
                if (ntx < 4) begin
                    lg_addr[ntx] = cmd_addr; lg_wr[ntx] = cmd_write; lg_wd[ntx] = cmd_wdata;
                end
                ntx++;
                wcnt = int'(v.lat);
            end else if (wcnt > 0) begin
                wcnt--;
                if (wcnt == 0) begin
                    cmd_done = 1'b1;
                    cmd_err = (int'(v.err_at) == ntx);
                    cmd_rdata = v.rd;
                end
            end
        end
        req_valid = 1'b0;
        chk(got, "R8 done seen", 32'(got), 32'd1);
        chk(!overlap, "R9 no command while outstanding", 32'(overlap), 32'd0);
        chk(ntx == n_exp, "R1/R6/R7 command count", 32'(ntx), 32'(n_exp));
        chk(k_act == k_exp, "R1/R5/R7 err_kind", 32'(k_act), 32'(k_exp));
        chk(rd_act == rd_exp, "R5/R6 rd_data", 32'(rd_act), 32'(rd_exp));
        if (ntx >= 1 && n_exp >= 1) begin
            chk(lg_addr[0] == 16'h8028 && lg_wr[0], "R2 ctrl address/dir",
                {15'd0, lg_wr[0], lg_addr[0]}, {16'h0001, 16'h8028});
            chk(lg_wd[0] == (v.wr ? 16'h0 : 16'h1), "R2 ctrl data", 32'(lg_wd[0]), v.wr ? 32'd0 : 32'd1);
        end
        if (ntx >= 2 && n_exp >= 2) begin
            chk(lg_addr[1] == win_of(v) && lg_wr[1], "R3 window address", 32'(lg_addr[1]), 32'(win_of(v)));
            chk(lg_wd[1] == (v.wr ? v.wd : 16'h0), "R4 window data", 32'(lg_wd[1]), v.wr ? 32'(v.wd) : 32'd0);
        end
        if (ntx >= 3 && n_exp >= 3) begin
            chk(lg_addr[2] == 16'h8029 && !lg_wr[2], "R5 data read address/dir",
                {15'd0, lg_wr[2], lg_addr[2]}, {16'h0000, 16'h8029});
        end
        @(negedge clk);
        chk(!done && !busy, "R8 idle after done", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !cmd_req && err_kind == 2'd0 && rd_data == 16'h0,
            "R10 reset state", {11'd0, busy, done, cmd_req, err_kind, rd_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cmd_req, "R10 idle after reset", {30'd0, busy, cmd_req}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // Reset in the middle of a read aborts everything
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_phy = 5'd1; req_page = 4'd0; req_reg = 6'd5;
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_req == 1'b1, "R2 first command issued", 32'(cmd_req), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !cmd_req && !done, "R10 reset mid-sequence", {29'd0, busy, cmd_req, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule